// File: doc/BRIEF.md
# Receive Message Object Allocator

This block places each received and accepted CAN frame into a bank of message objects. Every object carries its own acceptance setup: a valid flag, a frame format (standard or extended), a direction bit, an identifier, an optional acceptance mask and an end-of-chain marker. When a frame arrives, a sequential scan checks one object per cycle, starting from object 0. The frame goes into the first valid object whose identifier matches and whose new-data flag is clear. Writing a frame sets that object's new-data and interrupt-pending flags. Both flag sets appear as per-object vectors for the processor side.

Several objects with the same acceptance setup form a receive queue. In that queue every member except the last has its end-of-chain marker clear. Occupied members are skipped. If all members of the queue are occupied, the frame overwrites the member that carries the marker and raises that member's message-lost flag. A processor-side clear port releases an object after it has been read. A configuration port loads an object's acceptance setup. A read port returns the stored content of any object.

Top module: `rxObjAlloc`

## Requirements
- R1: A frame is written into the lowest-numbered valid object that matches it and whose new-data flag is clear.
- R2: Writing a frame into object k sets bit k of `newDatVec` and bit k of `intPndVec`, with object 0 in bit 0. The cycle in which these bits first read 1 is the cycle in which `storeDone` is high with `storeIdx` = k. Neither vector gains a set bit at any other time.
- R3: A matching object whose new-data flag is set and whose end-of-chain marker is clear is skipped, and the scan continues with the next object.
- R4: A matching object whose new-data flag is set and whose end-of-chain marker is set is overwritten. In that case `storeLost` reads 1 with `storeDone`, and the object's `rdLost` flag stays at 1 until the object is cleared.
- R5: The match key has 30 bits: {direction, arbitration identifier}. When use-mask is 0, all 30 bits must be equal. When use-mask is 1, only the key bits that are 1 in `cfgMask` take part, and mask bit 29 covers the direction bit. In both cases the frame format of the frame must equal that of the object.
- R6: In the arbitration form, an extended identifier occupies bits 28:0. A standard identifier (`frmId[10:0]`) occupies bits 28:18, with zeros below. Objects are configured with `cfgId` in this form, and `rdId` returns the stored frame in this form.
- R7: A remote frame (`frmRtr`=1) has direction bit 1. It is stored with `rdRtr`=1, with its DLC unchanged, and with all data bytes at zero.
- R8: `busy` rises in the cycle after a frame is accepted and stays high until that frame has been written or dropped. A frame offered while `busy` is high is ignored and changes no object.
- R9: The scan covers one object per cycle. If the frame is accepted at clock edge E0 and written into object k, `storeDone` is high right after edge E0+k+2. If no object takes the frame, `dropped` is high right after edge E0+NUM_OBJ.
- R10: A clear of object k (`clrEn`) or a configuration write to object k (`cfgEn`) resets its new-data, interrupt-pending and message-lost flags. If a frame is written into the same object in the same cycle, the write takes precedence.
- R11: An object with its valid flag clear never takes a frame.
- R12: A frame that no object takes raises `dropped` for one cycle and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | Offers a received frame for one cycle |
| frmXtd | input | 1 | Frame uses an extended identifier |
| frmRtr | input | 1 | Frame is a remote frame |
| frmId | input | 29 | Raw identifier; standard frames use bits 10:0 |
| frmDlc | input | 4 | Data length code |
| frmData | input | 64 | Data bytes, byte 0 in bits 7:0 |
| busy | output | 1 | A scan or write is in progress |
| cfgEn | input | 1 | Loads the acceptance setup of object `cfgIdx` |
| cfgIdx | input | 4 | Object index for a configuration write |
| cfgValid | input | 1 | Object takes part in reception |
| cfgUseMask | input | 1 | Apply `cfgMask` during the compare |
| cfgEob | input | 1 | End-of-chain marker |
| cfgXtd | input | 1 | Frame format the object accepts |
| cfgDir | input | 1 | Direction bit of the object key |
| cfgId | input | 29 | Identifier in arbitration form |
| cfgMask | input | 30 | Compare mask; bit 29 covers direction |
| clrEn | input | 1 | Clears the flags of object `clrIdx` |
| clrIdx | input | 4 | Object index for a clear |
| rdIdx | input | 4 | Object index for the read port |
| rdXtd | output | 1 | Stored frame format |
| rdRtr | output | 1 | Stored frame was a remote frame |
| rdId | output | 29 | Stored identifier in arbitration form |
| rdDlc | output | 4 | Stored data length code |
| rdData | output | 64 | Stored data bytes |
| rdLost | output | 1 | Message-lost flag of the object |
| newDatVec | output | 16 | New-data flag for each object |
| intPndVec | output | 16 | Interrupt-pending flag for each object |
| storeDone | output | 1 | One-cycle pulse after an object has been written |
| storeIdx | output | 4 | Object index of the last write |
| storeLost | output | 1 | The last write overwrote unread data |
| dropped | output | 1 | One-cycle pulse when no object took the frame |

## Verification
The hardest situation to reach is the overwrite of the end-of-chain object. It needs every member of a queue occupied at once, so the stimulus sends repeated frames with the same identifier until all members are full and then sends one more. Clearing a lower member in the middle of the sequence then shows that the lowest free member is reused. A second case offers a frame while the scan is still running and checks that it is ignored. Scan latency is measured up to the last object.

// File: rtl/rxAllocPkg.sv
package rxAllocPkg;

  localparam int ID_W   = 29;
  localparam int KEY_W  = ID_W + 1;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int STD_W  = 11;

  typedef struct packed {
    logic              valid;
    logic              useMask;
    logic              eob;
    logic              xtd;
    logic              dir;
    logic [ID_W-1:0]   id;
    logic [KEY_W-1:0]  mask;
  } objCfg_t;

  typedef struct packed {
    logic              xtd;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [ID_W-1:0]   arbId;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef struct packed {
    logic latchFrame;
    logic writeObj;
    logic dropFrame;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WRITE
  } allocState_t;

  function automatic logic [ID_W-1:0] toArbForm(input logic xtd, input logic [ID_W-1:0] rawId);
    if (xtd) toArbForm = rawId;
    else     toArbForm = {rawId[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
  endfunction

endpackage

// File: rtl/rxAllocCtrl.sv
module rxAllocCtrl
  import rxAllocPkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic             takeHere,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  allocState_t stateQ;

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_IDLE:  strobe.latchFrame = frmValid;
      ST_SCAN:  strobe.dropFrame  = !takeHere && (scanIdx == LAST_IDX);
      ST_WRITE: strobe.writeObj   = 1'b1;
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (frmValid) begin
            stateQ  <= ST_SCAN;
            scanIdx <= '0;
          end
        end
        ST_SCAN: begin
          if (takeHere)                  stateQ  <= ST_WRITE;
          else if (scanIdx == LAST_IDX)  stateQ  <= ST_IDLE;
          else                           scanIdx <= scanIdx + 1'b1;
        end
        ST_WRITE: stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/rxAllocData.sv
module rxAllocData
  import rxAllocPkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [IDX_W-1:0]  scanIdx,
  input  logic              frmXtd,
  input  logic              frmRtr,
  input  logic [ID_W-1:0]   frmId,
  input  logic [DLC_W-1:0]  frmDlc,
  input  logic [DATA_W-1:0] frmData,
  input  logic              cfgEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  objCfg_t           cfgWord,
  input  logic              clrEn,
  input  logic [IDX_W-1:0]  clrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              takeHere,
  output logic              rdXtd,
  output logic              rdRtr,
  output logic [ID_W-1:0]   rdId,
  output logic [DLC_W-1:0]  rdDlc,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLost,
  output logic [NUM_OBJ-1:0] newDatVec,
  output logic [NUM_OBJ-1:0] intPndVec,
  output logic              storeDone,
  output logic [IDX_W-1:0]  storeIdx,
  output logic              storeLost,
  output logic              dropped
);

  frame_t  frmQ;
  objCfg_t cfgArr  [NUM_OBJ];
  frame_t  bodyArr [NUM_OBJ];
  logic [NUM_OBJ-1:0] matchVec;
  logic [NUM_OBJ-1:0] lostVec;
  logic [KEY_W-1:0]   frmKey;

  assign frmKey = {frmQ.rtr, frmQ.arbId};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmQ <= '0;
    end else if (strobe.latchFrame) begin
      frmQ.xtd   <= frmXtd;
      frmQ.rtr   <= frmRtr;
      frmQ.dlc   <= frmDlc;
      frmQ.arbId <= toArbForm(frmXtd, frmId);
      frmQ.data  <= frmRtr ? '0 : frmData;
    end
  end

  for (genvar k = 0; k < NUM_OBJ; k++) begin : gObj
    objCfg_t          cfgR;
    frame_t           bodyR;
    logic             newDatR, intPndR, lostR;
    logic             hitW, clrW, cfgW;
    logic [KEY_W-1:0] objKey, cmpMask;

    assign hitW    = strobe.writeObj && (scanIdx == IDX_W'(k));
    assign clrW    = clrEn && (clrIdx == IDX_W'(k));
    assign cfgW    = cfgEn && (cfgIdx == IDX_W'(k));
    assign objKey  = {cfgR.dir, cfgR.id};
    assign cmpMask = cfgR.useMask ? cfgR.mask : {KEY_W{1'b1}};

    assign matchVec[k] = cfgR.valid && (cfgR.xtd == frmQ.xtd) &&
                         (((objKey ^ frmKey) & cmpMask) == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgR    <= '0;
        bodyR   <= '0;
        newDatR <= 1'b0;
        intPndR <= 1'b0;
        lostR   <= 1'b0;
      end else begin
        if (cfgW) cfgR <= cfgWord;
        if (hitW) begin
          bodyR   <= frmQ;
          newDatR <= 1'b1;
          intPndR <= 1'b1;
          lostR   <= lostR | newDatR;
        end else if (clrW || cfgW) begin
          newDatR <= 1'b0;
          intPndR <= 1'b0;
          lostR   <= 1'b0;
        end
      end
    end

    assign cfgArr[k]    = cfgR;
    assign bodyArr[k]   = bodyR;
    assign newDatVec[k] = newDatR;
    assign intPndVec[k] = intPndR;
    assign lostVec[k]   = lostR;
  end

  assign takeHere = matchVec[scanIdx] && (!newDatVec[scanIdx] || cfgArr[scanIdx].eob);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeDone <= 1'b0;
      storeIdx  <= '0;
      storeLost <= 1'b0;
      dropped   <= 1'b0;
    end else begin
      storeDone <= strobe.writeObj;
      dropped   <= strobe.dropFrame;
      if (strobe.writeObj) begin
        storeIdx  <= scanIdx;
        storeLost <= newDatVec[scanIdx];
      end
    end
  end

  assign rdXtd  = bodyArr[rdIdx].xtd;
  assign rdRtr  = bodyArr[rdIdx].rtr;
  assign rdId   = bodyArr[rdIdx].arbId;
  assign rdDlc  = bodyArr[rdIdx].dlc;
  assign rdData = bodyArr[rdIdx].data;
  assign rdLost = lostVec[rdIdx];

endmodule

// File: rtl/rxObjAlloc.sv
module rxObjAlloc
  import rxAllocPkg::*;
#(
  parameter  int NUM_OBJ = 16,
  localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frmValid,
  input  logic               frmXtd,
  input  logic               frmRtr,
  input  logic [ID_W-1:0]    frmId,
  input  logic [DLC_W-1:0]   frmDlc,
  input  logic [DATA_W-1:0]  frmData,
  output logic               busy,
  input  logic               cfgEn,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgValid,
  input  logic               cfgUseMask,
  input  logic               cfgEob,
  input  logic               cfgXtd,
  input  logic               cfgDir,
  input  logic [ID_W-1:0]    cfgId,
  input  logic [KEY_W-1:0]   cfgMask,
  input  logic               clrEn,
  input  logic [IDX_W-1:0]   clrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic               rdXtd,
  output logic               rdRtr,
  output logic [ID_W-1:0]    rdId,
  output logic [DLC_W-1:0]   rdDlc,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdLost,
  output logic [NUM_OBJ-1:0] newDatVec,
  output logic [NUM_OBJ-1:0] intPndVec,
  output logic               storeDone,
  output logic [IDX_W-1:0]   storeIdx,
  output logic               storeLost,
  output logic               dropped
);

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             takeHere;
  objCfg_t          cfgWord;

  assign cfgWord = '{valid: cfgValid, useMask: cfgUseMask, eob: cfgEob,
                     xtd: cfgXtd, dir: cfgDir, id: cfgId, mask: cfgMask};

  rxAllocCtrl #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .takeHere (takeHere),
    .strobe   (strobe),
    .scanIdx  (scanIdx),
    .busy     (busy)
  );

  rxAllocData #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .scanIdx   (scanIdx),
    .frmXtd    (frmXtd),
    .frmRtr    (frmRtr),
    .frmId     (frmId),
    .frmDlc    (frmDlc),
    .frmData   (frmData),
    .cfgEn     (cfgEn),
    .cfgIdx    (cfgIdx),
    .cfgWord   (cfgWord),
    .clrEn     (clrEn),
    .clrIdx    (clrIdx),
    .rdIdx     (rdIdx),
    .takeHere  (takeHere),
    .rdXtd     (rdXtd),
    .rdRtr     (rdRtr),
    .rdId      (rdId),
    .rdDlc     (rdDlc),
    .rdData    (rdData),
    .rdLost    (rdLost),
    .newDatVec (newDatVec),
    .intPndVec (intPndVec),
    .storeDone (storeDone),
    .storeIdx  (storeIdx),
    .storeLost (storeLost),
    .dropped   (dropped)
  );

endmodule

// File: rtl/rxObjAllocChecker.sv
module rxObjAllocChecker #(
  parameter int NUM_OBJ = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               frmValid,
  input logic               busy,
  input logic [NUM_OBJ-1:0] newDatVec,
  input logic [NUM_OBJ-1:0] intPndVec,
  input logic               storeDone,
  input logic [IDX_W-1:0]   storeIdx,
  input logic               storeLost,
  input logic               dropped
);

  logic [NUM_OBJ-1:0] prevNew;
  int unsigned        busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNew <= '0;
      busyRun <= 0;
    end else begin
      prevNew <= newDatVec;
      busyRun <= busy ? busyRun + 1 : 0;
    end
  end

  p_flags_on_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeDone |-> (newDatVec[storeIdx] && intPndVec[storeIdx]));

  p_new_rises_only_on_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((newDatVec & ~$past(newDatVec)) != '0) |-> storeDone);

  p_pend_rises_only_on_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((intPndVec & ~$past(intPndVec)) != '0) |-> storeDone);

  p_lost_tracks_prior_r4: assert property (@(posedge clk) disable iff (!rstN)
    storeDone |-> (storeLost == prevNew[storeIdx]));

  p_accept_raises_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !busy) |=> busy);

  p_result_ends_scan_r8: assert property (@(posedge clk) disable iff (!rstN)
    (storeDone || dropped) |-> !busy);

  p_single_result_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(storeDone && dropped));

  p_scan_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= NUM_OBJ + 1);

endmodule

bind rxObjAlloc rxObjAllocChecker #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frmValid  (frmValid),
  .busy      (busy),
  .newDatVec (newDatVec),
  .intPndVec (intPndVec),
  .storeDone (storeDone),
  .storeIdx  (storeIdx),
  .storeLost (storeLost),
  .dropped   (dropped)
);

// File: tb/rxObjAlloc_test.sv
module rxObjAlloc_test;

  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frmValid = 0, frmXtd = 0, frmRtr = 0;
  logic [28:0] frmId = '0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic busy;
  logic cfgEn = 0, cfgValid = 0, cfgUseMask = 0, cfgEob = 0, cfgXtd = 0, cfgDir = 0;
  logic [IW-1:0] cfgIdx = '0, clrIdx = '0, rdIdx = '0;
  logic [28:0] cfgId = '0;
  logic [29:0] cfgMask = '0;
  logic clrEn = 0;
  logic rdXtd, rdRtr, rdLost;
  logic [28:0] rdId;
  logic [3:0]  rdDlc;
  logic [63:0] rdData;
  logic [N-1:0] newDatVec, intPndVec;
  logic storeDone, storeLost, dropped;
  logic [IW-1:0] storeIdx;

  rxObjAlloc #(.NUM_OBJ(N)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    int          idx;
    bit          lost;
    bit          rdLostExp;
    int          due;
    logic [28:0] arb;
    bit          xtd;
    bit          rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  bit          mValid[N], mUse[N], mEob[N], mXtd[N], mDir[N], mNew[N], mLost[N];
  logic [28:0] mId[N];
  logic [29:0] mMask[N];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] arbOf(input bit xtd, input logic [28:0] id);
    return xtd ? id : {id[10:0], 18'b0};
  endfunction

  function automatic logic [N-1:0] modelNew();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = mNew[k];
    return v;
  endfunction

  task automatic cfgObj(input int idx, input bit valid, input bit useMask, input bit eob,
                        input bit xtd, input bit dir, input logic [28:0] id, input logic [29:0] mask);
    @(negedge clk);
    cfgEn = 1; cfgIdx = IW'(idx); cfgValid = valid; cfgUseMask = useMask; cfgEob = eob;
    cfgXtd = xtd; cfgDir = dir; cfgId = id; cfgMask = mask;
    @(negedge clk);
    cfgEn = 0;
    mValid[idx] = valid; mUse[idx] = useMask; mEob[idx] = eob; mXtd[idx] = xtd;
    mDir[idx] = dir; mId[idx] = id; mMask[idx] = mask;
    mNew[idx] = 0; mLost[idx] = 0;
  endtask

  task automatic clrObj(input int idx);
    @(negedge clk);
    clrEn = 1; clrIdx = IW'(idx);
    @(negedge clk);
    clrEn = 0;
    mNew[idx] = 0; mLost[idx] = 0;
  endtask

  task automatic sendFrame(input string tag, input bit xtd, input bit rtr, input logic [28:0] id,
                           input logic [3:0] dlc, input logic [63:0] data, input bit poke);
    expItem_t it;
    logic [29:0] fKey, oKey, cm;
    it.idx = -1; it.lost = 0;
    fKey = {rtr, arbOf(xtd, id)};
    for (int k = 0; k < N; k++) begin
      oKey = {mDir[k], mId[k]};
      cm   = mUse[k] ? mMask[k] : '1;
      if (it.idx < 0 && mValid[k] && mXtd[k] == xtd && ((oKey ^ fKey) & cm) == '0) begin
        if (!mNew[k]) it.idx = k;
        else if (mEob[k]) begin it.idx = k; it.lost = 1; end
      end
    end
    it.arb = arbOf(xtd, id); it.xtd = xtd; it.rtr = rtr; it.dlc = dlc;
    it.data = rtr ? 64'h0 : data; it.tag = tag;
    @(negedge clk);
    it.due = (it.idx >= 0) ? cyc + it.idx + 3 : cyc + N + 1;
    if (it.idx >= 0) begin
      mLost[it.idx] = mLost[it.idx] | mNew[it.idx];
      mNew[it.idx]  = 1;
      it.rdLostExp  = mLost[it.idx];
    end
    expQ.push_back(it);
    frmValid = 1; frmXtd = xtd; frmRtr = rtr; frmId = id; frmDlc = dlc; frmData = data;
    @(negedge clk);
    if (poke) begin
      frmXtd = 0; frmRtr = 0; frmId = 29'h500; frmData = 64'hDEAD;
    end else begin
      frmValid = 0;
    end
    @(negedge clk);
    frmValid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(newDatVec == modelNew(), {tag, " newDatVec"}, 64'(newDatVec), 64'(modelNew()));
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && (storeDone || dropped)) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected result", 64'(storeIdx), 64'hFFFF);
        end else begin
          it = expQ.pop_front();
          check(storeDone == (it.idx >= 0), {it.tag, " R12 stored/dropped"}, 64'(storeDone), 64'(it.idx >= 0));
          check(cyc == it.due, {it.tag, " R9 latency"}, 64'(cyc), 64'(it.due));
          if (storeDone && it.idx >= 0) begin
            check(int'(storeIdx) == it.idx, {it.tag, " R1 object"}, 64'(storeIdx), 64'(it.idx));
            check(storeLost == it.lost, {it.tag, " R4 storeLost"}, 64'(storeLost), 64'(it.lost));
            check(newDatVec[storeIdx] && intPndVec[storeIdx], {it.tag, " R2 flags"},
                  64'({newDatVec[storeIdx], intPndVec[storeIdx]}), 64'h3);
            rdIdx = storeIdx;
            #1;
            check(rdId == it.arb && rdXtd == it.xtd, {it.tag, " R6 id"}, 64'(rdId), 64'(it.arb));
            check(rdRtr == it.rtr && rdDlc == it.dlc, {it.tag, " R7 rtr/dlc"},
                  64'({rdRtr, rdDlc}), 64'({it.rtr, it.dlc}));
            check(rdData == it.data, {it.tag, " R7 data"}, rdData, it.data);
            check(rdLost == it.rdLostExp, {it.tag, " R4 rdLost"}, 64'(rdLost), 64'(it.rdLostExp));
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  localparam logic [29:0] FULL = '1;

  initial begin : driver
    for (int k = 0; k < N; k++) begin
      mValid[k] = 0; mUse[k] = 0; mEob[k] = 0; mXtd[k] = 0; mDir[k] = 0;
      mNew[k] = 0; mLost[k] = 0; mId[k] = '0; mMask[k] = '0;
    end
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(newDatVec == '0 && intPndVec == '0, "R2 reset flags", 64'({newDatVec, intPndVec}), 64'h0);
    check(busy == 0 && storeDone == 0 && dropped == 0, "R8 reset idle",
          64'({busy, storeDone, dropped}), 64'h0);

    for (int k = 0; k < 4; k++) cfgObj(k, 1, 0, k == 3, 0, 0, arbOf(0, 29'h123), FULL);
    cfgObj(5, 1, 0, 1, 1, 0, 29'h1ABCDEF, FULL);
    cfgObj(6, 1, 1, 1, 0, 0, arbOf(0, 29'h240), {1'b1, 11'h7F0, 18'b0});
    cfgObj(8, 1, 0, 1, 0, 1, arbOf(0, 29'h300), FULL);
    cfgObj(12, 1, 1, 1, 0, 0, arbOf(0, 29'h400), {1'b0, 11'h7FF, 18'b0});
    cfgObj(13, 1, 0, 1, 0, 0, arbOf(0, 29'h500), FULL);
    cfgObj(14, 0, 0, 1, 0, 0, arbOf(0, 29'h777), FULL);
    cfgObj(15, 1, 0, 1, 0, 0, arbOf(0, 29'h7FF), FULL);

    sendFrame("R1 first into chain", 0, 0, 29'h123, 4'd8, 64'h1111_2222_3333_4444, 0);
    sendFrame("R3 skip to obj1", 0, 0, 29'h123, 4'd2, 64'h0000_0000_0000_ABCD, 0);
    sendFrame("R3 skip to obj2", 0, 0, 29'h123, 4'd8, 64'h5555_6666_7777_8888, 0);
    sendFrame("R3 fill eob obj3", 0, 0, 29'h123, 4'd1, 64'h0000_0000_0000_0042, 0);
    sendFrame("R4 overwrite eob", 0, 0, 29'h123, 4'd3, 64'h0000_0000_00C0_FFEE, 0);

    clrObj(1);
    check(newDatVec[1] == 0 && intPndVec[1] == 0, "R10 clear obj1",
          64'({newDatVec[1], intPndVec[1]}), 64'h0);
    sendFrame("R1 reuse lowest free", 0, 0, 29'h123, 4'd4, 64'h0000_0000_1234_5678, 0);

    sendFrame("R6 extended match", 1, 0, 29'h1ABCDEF, 4'd8, 64'hFEDC_BA98_7654_3210, 0);
    sendFrame("R12 format mismatch drop", 1, 0, 29'h123, 4'd1, 64'h1, 0);
    sendFrame("R5 masked accept", 0, 0, 29'h24A, 4'd5, 64'h0000_00AA_BBCC_DDEE, 0);
    sendFrame("R5 masked reject", 0, 0, 29'h25A, 4'd5, 64'h1, 0);
    sendFrame("R7 remote stored", 0, 1, 29'h300, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    sendFrame("R5 direction reject", 0, 0, 29'h300, 4'd6, 64'h2, 0);
    sendFrame("R5 dir masked remote", 0, 1, 29'h400, 4'd2, 64'h3, 0);
    sendFrame("R4 dir masked overwrite", 0, 0, 29'h400, 4'd2, 64'h0000_0000_0000_9999, 0);
    sendFrame("R11 invalid object drop", 0, 0, 29'h777, 4'd1, 64'h4, 0);

    for (int k = 0; k < 4; k++) clrObj(k);
    sendFrame("R8 offer while busy", 0, 0, 29'h123, 4'd8, 64'h0102_0304_0506_0708, 1);
    check(newDatVec[13] == 0, "R8 busy offer ignored", 64'(newDatVec[13]), 64'h0);

    sendFrame("R9 last object latency", 0, 0, 29'h7FF, 4'd7, 64'h00AB_CDEF_0011_2233, 0);

    cfgObj(12, 1, 1, 1, 0, 0, arbOf(0, 29'h400), {1'b0, 11'h7FF, 18'b0});
    rdIdx = 4'd12;
    #1;
    check(newDatVec[12] == 0 && intPndVec[12] == 0 && rdLost == 0, "R10 config clears flags",
          64'({newDatVec[12], intPndVec[12], rdLost}), 64'h0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R12 all results seen", 64'(expQ.size()), 64'h0);
    finishRun();
  end

endmodule